// File: doc/BRIEF.md
# Three-Channel Quadrature Encoder Timer Group

The block holds three 16-bit up/down timers and one free-running auxiliary timer, all reachable through a small register port. Every main timer has a control register with a 3-bit mode field. Mode 000 is plain counting: the timer steps once per clock while its run bit is set, upward or downward. Mode 110 turns the timer into an incremental encoder counter. It then decodes two phase inputs and watches an index input. Any other mode code freezes the count.

In encoder mode the phase inputs go through a two-flop synchronizer and a stability filter. Every accepted edge of either phase moves the count by one, which gives four counts per encoder line. A change on both phases in the same sample is not counted and sets a sticky error flag. When the count wraps in either direction it sets a sticky wrap flag. If its enable bit is set, the index input clears the count on a rising edge.

The auxiliary timer can run freely. A capture-enable bit in its control register makes every count step of the middle timer copy the auxiliary value into a capture/reload register. Software can also write that register directly.

Top module: `qt_group`

## Requirements
- R1: After reset, every register (three timer controls, auxiliary control, three counts, auxiliary count, capture) reads as zero.
- R2: With mode field [2:0] = 110, each accepted change of exactly one phase moves the count by one. An edge on phase A counts up when the new A level differs from B, otherwise down. An edge on phase B counts up when the new B level equals A, otherwise down. A rising A with B low therefore counts up, and one full cycle 00,10,11,01,00 of (A,B) adds four.
- R3: The three timers decode their own phase inputs independently. Steps on one timer leave the other counts unchanged.
- R4: A phase level that lasts only one clock is never accepted and does not change the count.
- R5: In encoder mode, a change of both phases in the same sample leaves the count unchanged and sets control bit 6 (sticky error). Writing the control register with bit 6 = 1 clears that bit.
- R6: In encoder mode with control bit 5 (index enable) = 1, a rising edge on the index input clears the count to 0. With bit 5 = 0 the index input has no effect.
- R7: The count wraps modulo 2^16 in both directions. A wrap sets control bit 7 (sticky), and writing the control register with bit 7 = 1 clears it.
- R8: With auxiliary control bit 1 (capture enable) = 1, each count step of the middle timer (timer 1) copies the auxiliary count into the capture register.
- R9: With capture enable = 0, steps of timer 1 leave the capture register unchanged.
- R10: In mode 000 with control bit 3 (run) = 1, the count changes by one each clock: upward when bit 4 = 0, downward when bit 4 = 1. With a mode code other than 000 or 110 the count holds. With auxiliary control bit 0 = 1, the auxiliary count rises by one each clock.
- R11: Register map: addresses 0 to 2 hold timer controls, 3 the auxiliary control, 4 to 6 the timer counts, 7 the auxiliary count and 8 the capture register. A write to a count address loads that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| enc_a | input | 3 | Phase A, one bit per timer |
| enc_b | input | 3 | Phase B, one bit per timer |
| enc_idx | input | 3 | Index input, one bit per timer |

## Verification
The hold and single-step properties assume that no register write lands in the same cycle as a decoded phase change. The stimulus meets this because every phase change waits eight clocks before the next access. Each encoder step changes a single phase, except in the scenario that toggles both phases together on purpose. The phase inputs stay at zero through reset, so the filter starts in agreement with the pins and no step appears after reset.

// File: rtl/qt_pkg.sv
package qt_pkg;
    localparam int          CNT_W    = 16;
    localparam logic [2:0]  MODE_CNT = 3'b000;
    localparam logic [2:0]  MODE_ENC = 3'b110;

    // control fields, mode in the low bits
    typedef struct packed {
        logic       idx_en;
        logic       down;
        logic       run;
        logic [2:0] mode;
    } tctl_t;
endpackage

// File: rtl/qt_in_filter.sv
module qt_in_filter #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_i,
    input  logic       b_i,
    input  logic       idx_i,
    output logic [1:0] ab_o,
    output logic       idx_rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][2:0] sy;
        logic [1:0]             hist;
        logic [1:0]             acc;
        logic                   idx_prev;
    } flt_t;

    flt_t s_d, s_q;
    logic [2:0] sync_w;

    assign sync_w = s_q.sy[STAGES-1];

    always_comb begin
        s_d          = s_q;
        s_d.sy[0]    = {a_i, b_i, idx_i};
        for (int i = 1; i < STAGES; i++) begin
            s_d.sy[i] = s_q.sy[i-1];
        end
        s_d.hist     = sync_w[2:1];
        if (sync_w[2:1] == s_q.hist) begin
            s_d.acc = s_q.hist;
        end
        s_d.idx_prev = sync_w[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ab_o       = s_q.acc;
    assign idx_rise_o = sync_w[0] & ~s_q.idx_prev;

    // R4
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_w[2:1] != s_q.hist) |=> $stable(s_q.acc));
endmodule

// File: rtl/qt_timer.sv
module qt_timer
    import qt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          cnt_we,
    input  logic [CW-1:0] wdata,
    input  logic [1:0]    ab_i,
    input  logic          idx_rise_i,
    output logic [CW-1:0] cnt_o,
    output logic [7:0]    ctl_o,
    output logic          step_o
);
    typedef struct packed {
        tctl_t         ctl;
        logic          err;
        logic          wrap;
        logic [1:0]    prev;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [1:0] chg;
    logic       enc, step, up, tick, dn, idx_clr;

    always_comb begin
        chg     = ab_i ^ s_q.prev;
        enc     = (s_q.ctl.mode == MODE_ENC);
        step    = enc && (chg == 2'b01 || chg == 2'b10);
        up      = chg[1] ? (ab_i[1] != ab_i[0]) : (ab_i[0] == ab_i[1]);
        tick    = step || (s_q.ctl.mode == MODE_CNT && s_q.ctl.run);
        dn      = step ? ~up : s_q.ctl.down;
        idx_clr = enc && s_q.ctl.idx_en && idx_rise_i;

        s_d      = s_q;
        s_d.prev = ab_i;
        if (tick) begin
            if (dn) begin
                if (s_q.cnt == '0) s_d.wrap = 1'b1;
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                if (&s_q.cnt) s_d.wrap = 1'b1;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (enc && chg == 2'b11) s_d.err = 1'b1;
        if (idx_clr)             s_d.cnt = '0;
        if (cnt_we)              s_d.cnt = wdata;
        if (ctl_we) begin
            s_d.ctl = tctl_t'(wdata[5:0]);
            if (wdata[6]) s_d.err  = 1'b0;
            if (wdata[7]) s_d.wrap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign ctl_o  = {s_q.wrap, s_q.err, s_q.ctl};
    assign step_o = step;

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !(ctl_we && wdata[6])) |=> s_q.err);

    // R5
    dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc && chg == 2'b11 && !cnt_we && !idx_clr) |=> (s_q.cnt == $past(s_q.cnt)));

    // R2
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_we && !idx_clr) |=>
            ((s_q.cnt - $past(s_q.cnt)) == CW'(1) || ($past(s_q.cnt) - s_q.cnt) == CW'(1)));
endmodule

// File: rtl/qt_group.sv
module qt_group
    import qt_pkg::*;
#(
    parameter int NT    = 3,
    parameter int CW    = CNT_W,
    parameter int AW    = 4,
    parameter int SYNC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    input  logic [NT-1:0] enc_a,
    input  logic [NT-1:0] enc_b,
    input  logic [NT-1:0] enc_idx
);
    localparam int MID      = NT / 2;
    localparam int A_AUXCTL = NT;
    localparam int A_CNT0   = NT + 1;
    localparam int A_AUXCNT = 2 * NT + 1;
    localparam int A_CAP    = 2 * NT + 2;

    typedef struct packed {
        logic          aux_run;
        logic          cap_en;
        logic [CW-1:0] aux;
        logic [CW-1:0] cap;
    } grp_t;

    grp_t st_d, st_q;

    logic [NT-1:0][CW-1:0] cnt_w;
    logic [NT-1:0][7:0]    ctl_w;
    logic [NT-1:0]         step_w;
    logic                  cap_we;

    for (genvar gi = 0; gi < NT; gi++) begin : g_ch
        logic [1:0] ab;
        logic       idx_rise;

        qt_in_filter #(.STAGES(SYNC)) u_flt (
            .clk        (clk),
            .rst_n      (rst_n),
            .a_i        (enc_a[gi]),
            .b_i        (enc_b[gi]),
            .idx_i      (enc_idx[gi]),
            .ab_o       (ab),
            .idx_rise_o (idx_rise)
        );

        qt_timer #(.CW(CW)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_we     (wr_en && addr == AW'(gi)),
            .cnt_we     (wr_en && addr == AW'(A_CNT0 + gi)),
            .wdata      (wdata),
            .ab_i       (ab),
            .idx_rise_i (idx_rise),
            .cnt_o      (cnt_w[gi]),
            .ctl_o      (ctl_w[gi]),
            .step_o     (step_w[gi])
        );
    end

    assign cap_we = wr_en && addr == AW'(A_CAP);

    always_comb begin
        st_d = st_q;
        if (st_q.aux_run)                st_d.aux = st_q.aux + 1'b1;
        if (st_q.cap_en && step_w[MID])  st_d.cap = st_q.aux;
        if (wr_en && addr == AW'(A_AUXCTL)) begin
            st_d.aux_run = wdata[0];
            st_d.cap_en  = wdata[1];
        end
        if (wr_en && addr == AW'(A_AUXCNT)) st_d.aux = wdata;
        if (cap_we)                         st_d.cap = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NT; i++) begin
            if (addr == AW'(i))          rdata = {{(CW-8){1'b0}}, ctl_w[i]};
            if (addr == AW'(A_CNT0 + i)) rdata = cnt_w[i];
        end
        if (addr == AW'(A_AUXCTL)) rdata = {{(CW-2){1'b0}}, st_q.cap_en, st_q.aux_run};
        if (addr == AW'(A_AUXCNT)) rdata = st_q.aux;
        if (addr == AW'(A_CAP))    rdata = st_q.cap;
    end

    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cap_en && !cap_we) |=> $stable(st_q.cap));

    // R8
    cap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cap_en && step_w[MID] && !cap_we) |=> (st_q.cap == $past(st_q.aux)));
endmodule

// File: tb/tb_qt_group.sv
module tb_qt_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  ea = '0, eb = '0, ei = '0;
    int          total = 0, bad = 0;

    qt_group dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .enc_a(ea), .enc_b(eb), .enc_idx(ei)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic enc_step(input int t, input bit up);
        logic [1:0] s, n;
        s = {ea[t], eb[t]};
        if (up) case (s) 2'b00: n = 2'b10; 2'b10: n = 2'b11; 2'b11: n = 2'b01; default: n = 2'b00; endcase
        else    case (s) 2'b00: n = 2'b01; 2'b01: n = 2'b11; 2'b11: n = 2'b10; default: n = 2'b00; endcase
        @(negedge clk);
        ea[t] = n[1]; eb[t] = n[0];
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            check("R1 reset", v, 16'h0000);
        end
    endtask

    task automatic t_load();
        logic [15:0] v;
        wr(4, 16'h00AB); rd(4, v); check("R11 load count0", v, 16'h00AB);
        wr(7, 16'h0F0F); rd(7, v); check("R11 load aux", v, 16'h0F0F);
        wr(8, 16'h0042); rd(8, v); check("R11 load capture", v, 16'h0042);
    endtask

    task automatic t_enc_basic();
        logic [15:0] v;
        wr(0, 16'h0006); wr(4, 16'h0000);
        enc_step(0, 1); rd(4, v); check("R2 A rise B low up", v, 16'h0001);
        for (int i = 0; i < 3; i++) enc_step(0, 1);
        rd(4, v); check("R2 four per line", v, 16'h0004);
        enc_step(0, 0); enc_step(0, 0);
        rd(4, v); check("R2 down", v, 16'h0002);
    endtask

    task automatic t_indep();
        logic [15:0] v;
        wr(1, 16'h0006); wr(2, 16'h0006); wr(5, 16'h0000); wr(6, 16'h000A);
        for (int i = 0; i < 3; i++) enc_step(1, 1);
        for (int i = 0; i < 5; i++) enc_step(2, 0);
        rd(5, v); check("R3 timer1", v, 16'h0003);
        rd(6, v); check("R3 timer2", v, 16'h0005);
        rd(4, v); check("R3 timer0 untouched", v, 16'h0002);
    endtask

    task automatic t_glitch();
        logic [15:0] v;
        @(negedge clk); ea[0] = ~ea[0];
        @(negedge clk); ea[0] = ~ea[0];
        repeat (8) @(negedge clk);
        rd(4, v); check("R4 one-clock glitch", v, 16'h0002);
    endtask

    task automatic t_err();
        logic [15:0] v;
        @(negedge clk); ea[0] = ~ea[0]; eb[0] = ~eb[0];
        repeat (8) @(negedge clk);
        rd(4, v); check("R5 count held", v, 16'h0002);
        rd(0, v); check("R5 err set", v & 16'h0040, 16'h0040);
        enc_step(0, 1);
        rd(0, v); check("R5 err sticky", v & 16'h0040, 16'h0040);
        rd(4, v); check("R5 counting resumes", v, 16'h0003);
        wr(0, 16'h0046);
        rd(0, v); check("R5 err cleared", v, 16'h0006);
    endtask

    task automatic t_index();
        logic [15:0] v;
        wr(0, 16'h0026);
        @(negedge clk); ei[0] = 1'b1;
        repeat (8) @(negedge clk);
        rd(4, v); check("R6 index clears", v, 16'h0000);
        ei[0] = 1'b0;
        wr(0, 16'h0006);
        enc_step(0, 1); enc_step(0, 1);
        @(negedge clk); ei[0] = 1'b1;
        repeat (8) @(negedge clk);
        rd(4, v); check("R6 index ignored when disabled", v, 16'h0002);
        ei[0] = 1'b0;
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        wr(6, 16'hFFFF);
        enc_step(2, 1);
        rd(6, v); check("R7 wrap up", v, 16'h0000);
        rd(2, v); check("R7 wrap flag", v & 16'h0080, 16'h0080);
        wr(2, 16'h0086);
        rd(2, v); check("R7 wrap cleared", v & 16'h0080, 16'h0000);
        enc_step(2, 0);
        rd(6, v); check("R7 wrap down", v, 16'hFFFF);
        rd(2, v); check("R7 wrap flag down", v & 16'h0080, 16'h0080);
    endtask

    task automatic t_plain();
        logic [15:0] v0, v1;
        wr(5, 16'h0064);
        wr(1, 16'h0008);
        rd(5, v0); repeat (5) @(posedge clk); rd(5, v1);
        check("R10 plain up", v1, v0 + 16'd5);
        wr(1, 16'h0018);
        rd(5, v0); repeat (5) @(posedge clk); rd(5, v1);
        check("R10 plain down", v1, v0 - 16'd5);
        wr(1, 16'h0009);
        rd(5, v0); repeat (5) @(posedge clk); rd(5, v1);
        check("R10 other mode holds", v1, v0);
        wr(3, 16'h0001);
        rd(7, v0); repeat (4) @(posedge clk); rd(7, v1);
        check("R10 aux runs", v1, v0 + 16'd4);
        wr(3, 16'h0000);
    endtask

    task automatic t_capture();
        logic [15:0] v;
        wr(7, 16'h1234); wr(3, 16'h0002); wr(1, 16'h0006);
        enc_step(1, 1);
        rd(8, v); check("R8 capture on timer1 step", v, 16'h1234);
        wr(3, 16'h0000); wr(7, 16'h5555);
        enc_step(1, 1);
        rd(8, v); check("R9 capture disabled", v, 16'h1234);
        wr(3, 16'h0002);
        enc_step(0, 1);
        rd(8, v); check("R8 timer0 step does not capture", v, 16'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_load();
        t_enc_basic();
        t_indep();
        t_glitch();
        t_err();
        t_index();
        t_wrap();
        t_plain();
        t_capture();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule